// File: doc/BRIEF.md
# Single-Master Two-Wire Bus Controller

This block drives a two-wire serial bus (clock and data, both open-drain) as the only master. It is meant for simple point-to-point access to devices such as serial EEPROMs or converters. Software, or a control engine above it, sends a stream of commands. The commands are generate a start condition, generate a stop condition, write one byte, and read one byte. The block turns each command into line activity timed by an internal half-bit divider. Nothing is automatic: a start or a stop happens only when it is commanded. No bus arbitration, no slave modes and no detection of a slave holding the clock are provided, and SCL is timed purely from the divider.

A write shifts out 8 bits, MSB first, and then samples the acknowledge bit that the slave returns. When a device is addressed, the written byte carries the 7-bit device address in its upper bits and the read(1)/write(0) flag in bit 0. A read releases SDA for 8 bits and shifts in what the slave drives. The block then drives an ACK on the ninth bit, or releases SDA to give a NACK when the command's ACK flag is clear. The last byte of a read is marked this way. Each byte raises a one-cycle completion pulse after its acknowledge bit. A write that is not acknowledged sets a sticky error flag. A received byte that arrives while the previous one is still unread sets a sticky overrun flag.

Commands enter through a valid/ready port. The fields are sampled only on the edge where valid and ready are both high, and valid may be withdrawn while ready is low. Received bytes leave through a valid/ready port. A byte stays valid, with its data stable, until ready is seen. Back-pressure on that port never stalls the bus: a new byte overwrites the old one and is flagged as an overrun.

Top module: `i2c_lite_master`

## Requirements
- R1: While reset is asserted, and after it is released, SCL and SDA are both released (drive-low outputs at 0), cmd_ready is 1, rx_valid is 0, both error flags are 0 and no completion pulse is present.
- R2: A start command (op 0) on a free bus pulls SDA low with SCL released for one half period H, then also pulls SCL low for H cycles, and then holds the bus with both lines low. On a held bus it first releases SDA with SCL low for H cycles, then releases SCL for H cycles, and then performs the same start sequence.
- R3: A stop command (op 1) on a held bus drives SDA low with SCL low for H cycles, then releases SCL for H cycles, then releases SDA for H cycles, and leaves the bus free.
- R4: A write command (op 2) on a held bus produces 9 clock periods. Each period is H cycles with SCL low followed by H cycles with SCL released. The 8 data bits go out MSB first, with SDA driven low for a 0 bit and released for a 1 bit. SDA is released during the ninth bit.
- R5: Every write or read produces exactly one cycle of xfer_done, in the first cycle after the ninth released-clock half. After that the bus is held with SCL low.
- R6: During byte transfers SDA changes only while SCL is driven low.
- R7: When the data line reads high at the end of the ninth released-clock half of a write, ack_err is set, and it stays set until err_clr.
- R8: A read command (op 3) releases SDA for 8 bits and samples the line at the end of each released-clock half, MSB first. On the ninth bit SDA is driven low if cmd_ack was 1, and released (NACK) if it was 0. The byte then appears on rx_data.
- R9: rx_valid stays high with rx_data stable until rx_ready is seen high. A byte that completes while rx_valid is high and rx_ready is low replaces the old byte and sets ovr_err, which stays set until err_clr.
- R10: cmd_ready is high only while the bus is free or held and no sequence is running. A command is taken on an edge where cmd_valid and cmd_ready are both high.
- R11: On a free bus, stop, write and read commands are taken and ignored: both lines stay released and no xfer_done is produced.
- R12: err_clr clears ack_err and ovr_err. If a flag is set on the same edge as err_clr, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command valid |
| cmd_ready_o | output | 1 | Command accepted when high together with valid |
| cmd_op_i | input | 2 | 0 start, 1 stop, 2 write, 3 read |
| cmd_data_i | input | 8 | Byte to write |
| cmd_ack_i | input | 1 | For reads: 1 drives ACK, 0 leaves NACK |
| rx_valid_o | output | 1 | Received byte available |
| rx_ready_i | input | 1 | Consumer takes the received byte |
| rx_data_o | output | 8 | Received byte |
| err_clr_i | input | 1 | Clears both error flags |
| ack_err_o | output | 1 | Sticky: write not acknowledged |
| ovr_err_o | output | 1 | Sticky: received byte overwritten before being read |
| xfer_done_o | output | 1 | One-cycle pulse per finished byte |
| scl_low_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_low_o | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_i | input | 1 | Resolved level of the SDA line |

## Verification
The bench runs the commands in several patterns. It sends commands to a free bus and checks that they are ignored. It issues starts both from a free bus and as repeated starts, which tells the two start paths apart. It writes alternating, all-ones and all-zeros bytes, which exposes bit order and polarity. A write is also answered with a slave NACK so that the error path is separate from the ACK path. Reads are run with the consumer stalled and with it ready, and with ACK and NACK on the ninth bit. These runs separate the overwrite-and-flag case from a normal hand-off and show how the ninth bit is driven. A behavioural model predicts each line level, handshake and flag cycle by cycle, and every cycle is compared against it.

// File: rtl/i2cl_pkg.sv
package i2cl_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE,    // bus free, both lines released
    S_HOLD,    // bus owned, SCL low
    S_RS_A,    // repeated start: release SDA, SCL low
    S_RS_B,    // repeated start: release SCL
    S_ST_A,    // start: SDA low, SCL released
    S_ST_B,    // start: SCL low
    S_SP_A,    // stop: SDA low, SCL low
    S_SP_B,    // stop: SCL released
    S_SP_C,    // stop: SDA released
    S_BIT_LO,  // bit cell, clock low half
    S_BIT_HI   // bit cell, clock released half
  } st_e;

endpackage

// File: rtl/i2cl_half_timer.sv
module i2cl_half_timer #(
  parameter int HALF_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = $clog2(HALF_CYC + 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == CW'(HALF_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run_i || tick_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q < CW'(HALF_CYC))); // R4

  AST_IDLE_COUNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i) |=> (cnt_q == '0)); // R4

endmodule

// File: rtl/i2cl_shifter.sv
module i2cl_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [DW-1:0] load_val_i,
  input  logic          shift_i,
  input  logic          sin_i,
  output logic [DW-1:0] data_o,
  output logic          nxt_msb_o
);
  logic [DW-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (load_i) begin
      sr_q <= load_val_i;
    end else if (shift_i) begin
      sr_q <= {sr_q[DW-2:0], sin_i};
    end
  end

  assign data_o    = sr_q;
  assign nxt_msb_o = sr_q[DW-2];

  AST_SHIFT_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !load_i) |=> (sr_q[DW-1:1] == $past(sr_q[DW-2:0]))); // R8

endmodule

// File: rtl/i2cl_rx_port.sv
module i2cl_rx_port #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          ready_i,
  input  logic          clr_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o,
  output logic          ovr_o
);
  logic          valid_q;
  logic [DW-1:0] data_q;
  logic          ovr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (push_i) begin
      valid_q <= 1'b1;
      data_q  <= push_data_i;
    end else if (valid_q && ready_i) begin
      valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
    end else if (push_i && valid_q && !ready_i) begin
      ovr_q <= 1'b1;
    end else if (clr_i) begin
      ovr_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign ovr_o   = ovr_q;

  AST_RX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !ready_i && !push_i) |=> (valid_q && $stable(data_q))); // R9

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !clr_i) |=> ovr_q); // R9

  AST_OVR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !push_i) |=> !ovr_q); // R12

endmodule

// File: rtl/i2cl_seq.sv
module i2cl_seq
  import i2cl_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid_i,
  output logic          cmd_ready_o,
  input  logic [1:0]    cmd_op_i,
  input  logic [DW-1:0] cmd_data_i,
  input  logic          cmd_ack_i,
  input  logic          tick_i,
  output logic          run_o,
  output logic          ld_o,
  output logic [DW-1:0] ld_val_o,
  output logic          shf_o,
  input  logic          nxt_msb_i,
  output logic          push_o,
  input  logic          sda_i,
  input  logic          err_clr_i,
  output logic          ack_err_o,
  output logic          done_o,
  output logic          scl_low_o,
  output logic          sda_low_o
);
  localparam int BW = $clog2(DW + 1);

  st_e           state_q, state_d;
  logic          sda_q, sda_d;
  logic [BW-1:0] bit_q, bit_d;
  logic          ackdrv_q, ackdrv_d;
  logic          rd_q, rd_d;
  logic          done_q, done_d;
  logic          ackerr_q, ackerr_set;
  logic          cmd_fire;
  op_e           op;

  assign op          = op_e'(cmd_op_i);
  assign cmd_ready_o = (state_q == S_IDLE) || (state_q == S_HOLD);
  assign cmd_fire    = cmd_valid_i && cmd_ready_o;
  assign run_o       = !cmd_ready_o;
  assign ld_val_o    = cmd_data_i;

  always_comb begin
    state_d    = state_q;
    sda_d      = sda_q;
    bit_d      = bit_q;
    ackdrv_d   = ackdrv_q;
    rd_d       = rd_q;
    done_d     = 1'b0;
    ld_o       = 1'b0;
    shf_o      = 1'b0;
    push_o     = 1'b0;
    ackerr_set = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (cmd_fire && op == OP_START) begin
          state_d = S_ST_A;
          sda_d   = 1'b1;
        end
      end
      S_HOLD: begin
        if (cmd_fire) begin
          unique case (op)
            OP_START: begin
              state_d = S_RS_A;
              sda_d   = 1'b0;
            end
            OP_STOP: begin
              state_d = S_SP_A;
              sda_d   = 1'b1;
            end
            default: begin
              state_d  = S_BIT_LO;
              ld_o     = 1'b1;
              bit_d    = '0;
              rd_d     = (op == OP_READ);
              ackdrv_d = (op == OP_READ) && cmd_ack_i;
              sda_d    = (op == OP_WRITE) ? ~cmd_data_i[DW-1] : 1'b0;
            end
          endcase
        end
      end
      S_RS_A: if (tick_i) begin state_d = S_RS_B; sda_d = 1'b0; end
      S_RS_B: if (tick_i) begin state_d = S_ST_A; sda_d = 1'b1; end
      S_ST_A: if (tick_i) state_d = S_ST_B;
      S_ST_B: if (tick_i) state_d = S_HOLD;
      S_SP_A: if (tick_i) begin state_d = S_SP_B; sda_d = 1'b1; end
      S_SP_B: if (tick_i) begin state_d = S_SP_C; sda_d = 1'b0; end
      S_SP_C: if (tick_i) state_d = S_IDLE;
      S_BIT_LO: if (tick_i) state_d = S_BIT_HI;
      S_BIT_HI: begin
        if (tick_i) begin
          if (bit_q == BW'(DW)) begin
            state_d = S_HOLD;
            done_d  = 1'b1;
            push_o  = rd_q;
            ackerr_set = !rd_q && sda_i;
          end else begin
            shf_o   = 1'b1;
            bit_d   = bit_q + 1'b1;
            state_d = S_BIT_LO;
            if (bit_q == BW'(DW - 1)) begin
              sda_d = ackdrv_q;
            end else begin
              sda_d = rd_q ? 1'b0 : ~nxt_msb_i;
            end
          end
        end
      end
      default: begin
        state_d = S_IDLE;
        sda_d   = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      sda_q    <= 1'b0;
      bit_q    <= '0;
      ackdrv_q <= 1'b0;
      rd_q     <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      sda_q    <= sda_d;
      bit_q    <= bit_d;
      ackdrv_q <= ackdrv_d;
      rd_q     <= rd_d;
      done_q   <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ackerr_q <= 1'b0;
    end else if (ackerr_set) begin
      ackerr_q <= 1'b1;
    end else if (err_clr_i) begin
      ackerr_q <= 1'b0;
    end
  end

  assign scl_low_o = (state_q == S_ST_B) || (state_q == S_HOLD) ||
                     (state_q == S_RS_A) || (state_q == S_SP_A) ||
                     (state_q == S_BIT_LO);
  assign sda_low_o = sda_q;
  assign done_o    = done_q;
  assign ack_err_o = ackerr_q;

  AST_SDA_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_BIT_HI) |-> $stable(sda_q)); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R5

  AST_DONE_LEAVES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (scl_low_o && cmd_ready_o)); // R5

  AST_ACKERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ackerr_q && !err_clr_i) |=> ackerr_q); // R7

  AST_XFER_STARTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && state_q == S_HOLD && (op == OP_WRITE || op == OP_READ))
      |=> (scl_low_o && !cmd_ready_o)); // R4

  AST_IDLE_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && state_q == S_IDLE && op != OP_START)
      |=> (!scl_low_o && !sda_low_o && !done_q)); // R11

endmodule

// File: rtl/i2c_lite_master.sv
module i2c_lite_master #(
  parameter int HALF_CYC = 4,
  parameter int DW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid_i,
  output logic          cmd_ready_o,
  input  logic [1:0]    cmd_op_i,
  input  logic [DW-1:0] cmd_data_i,
  input  logic          cmd_ack_i,
  output logic          rx_valid_o,
  input  logic          rx_ready_i,
  output logic [DW-1:0] rx_data_o,
  input  logic          err_clr_i,
  output logic          ack_err_o,
  output logic          ovr_err_o,
  output logic          xfer_done_o,
  output logic          scl_low_o,
  output logic          sda_low_o,
  input  logic          sda_i
);
  logic          run, tick;
  logic          ld, shf, push, nxt_msb;
  logic [DW-1:0] ld_val, sr_data;

  i2cl_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run),
    .tick_o (tick)
  );

  i2cl_shifter #(.DW(DW)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (ld),
    .load_val_i (ld_val),
    .shift_i    (shf),
    .sin_i      (sda_i),
    .data_o     (sr_data),
    .nxt_msb_o  (nxt_msb)
  );

  i2cl_seq #(.DW(DW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid_i (cmd_valid_i),
    .cmd_ready_o (cmd_ready_o),
    .cmd_op_i    (cmd_op_i),
    .cmd_data_i  (cmd_data_i),
    .cmd_ack_i   (cmd_ack_i),
    .tick_i      (tick),
    .run_o       (run),
    .ld_o        (ld),
    .ld_val_o    (ld_val),
    .shf_o       (shf),
    .nxt_msb_i   (nxt_msb),
    .push_o      (push),
    .sda_i       (sda_i),
    .err_clr_i   (err_clr_i),
    .ack_err_o   (ack_err_o),
    .done_o      (xfer_done_o),
    .scl_low_o   (scl_low_o),
    .sda_low_o   (sda_low_o)
  );

  i2cl_rx_port #(.DW(DW)) u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push),
    .push_data_i (sr_data),
    .ready_i     (rx_ready_i),
    .clr_i       (err_clr_i),
    .valid_o     (rx_valid_o),
    .data_o      (rx_data_o),
    .ovr_o       (ovr_err_o)
  );

endmodule

// File: tb/i2c_lite_master_tb_top.sv
`timescale 1ns/1ps
module i2c_lite_master_tb_top;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [1:0] cmd_op = 2'd0;
  logic [7:0] cmd_data = 8'h00;
  logic       cmd_ack = 1'b0;
  logic       rx_valid, rx_ready = 1'b0;
  logic [7:0] rx_data;
  logic       err_clr = 1'b0;
  logic       ack_err, ovr_err, xfer_done, scl_low, sda_low, sda_line;

  // bench-side slave response for the next command
  logic [7:0] sl_byte = 8'h00;
  logic       sl_nack = 1'b0;

  typedef struct packed {
    logic       scl;
    logic       sda;
    logic       slv;
    logic       last;
    logic [1:0] kind; // 0 start, 1 stop, 2 write, 3 read
  } ent_t;

  ent_t q[$];
  ent_t m_cur;
  logic m_busy, m_owned, m_hold_sda, m_done, m_rx_valid, m_ack_err, m_ovr;
  logic [7:0] m_rx_data;
  logic [1:0] p_op;
  logic [7:0] p_byte;
  logic p_nack, was_last, old_valid;

  int n_chk = 0, n_err = 0, n_done = 0;
  bit fin = 0;
  logic prev_scl, prev_sda;
  string tg;

  assign sda_line = !(sda_low || (m_busy && m_cur.slv));

  i2c_lite_master #(.HALF_CYC(HALF), .DW(8)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_op_i(cmd_op),
    .cmd_data_i(cmd_data), .cmd_ack_i(cmd_ack),
    .rx_valid_o(rx_valid), .rx_ready_i(rx_ready), .rx_data_o(rx_data),
    .err_clr_i(err_clr), .ack_err_o(ack_err), .ovr_err_o(ovr_err),
    .xfer_done_o(xfer_done), .scl_low_o(scl_low), .sda_low_o(sda_low),
    .sda_i(sda_line)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!fin) begin
      fin = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  task automatic seg(input logic s, input logic d, input logic v, input logic l, input logic [1:0] k);
    for (int i = 0; i < HALF; i++) q.push_back('{s, d, v, l && (i == HALF - 1), k});
  endtask

  // reference model, advanced on each rising edge from bench-driven inputs only
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      m_cur = '0; m_busy = 0; m_owned = 0; m_hold_sda = 0; m_done = 0;
      m_rx_valid = 0; m_rx_data = 8'h00; m_ack_err = 0; m_ovr = 0;
      p_op = 0; p_byte = 0; p_nack = 0;
    end else begin
      was_last  = m_busy && m_cur.last;
      old_valid = m_rx_valid;
      m_done    = 0;
      if (err_clr) begin m_ack_err = 0; m_ovr = 0; end
      if (old_valid && rx_ready) m_rx_valid = 0;
      if (was_last) begin
        m_done = 1;
        if (p_op == 2'd2 && p_nack) m_ack_err = 1;
        if (p_op == 2'd3) begin
          if (old_valid && !rx_ready) m_ovr = 1;
          m_rx_valid = 1;
          m_rx_data  = p_byte;
        end
      end
      if (!m_busy && cmd_valid) begin
        p_op = cmd_op; p_byte = sl_byte; p_nack = sl_nack;
        if (!m_owned) begin
          if (cmd_op == 2'd0) begin
            seg(0, 1, 0, 0, 0); seg(1, 1, 0, 0, 0);
            m_owned = 1; m_hold_sda = 1;
          end
        end else begin
          case (cmd_op)
            2'd0: begin
              seg(1, 0, 0, 0, 0); seg(0, 0, 0, 0, 0);
              seg(0, 1, 0, 0, 0); seg(1, 1, 0, 0, 0);
              m_hold_sda = 1;
            end
            2'd1: begin
              seg(1, 1, 0, 0, 1); seg(0, 1, 0, 0, 1); seg(0, 0, 0, 0, 1);
              m_owned = 0; m_hold_sda = 0;
            end
            2'd2: begin
              for (int b = 7; b >= 0; b--) begin
                seg(1, !cmd_data[b], 0, 0, 2); seg(0, !cmd_data[b], 0, 0, 2);
              end
              seg(1, 0, !sl_nack, 0, 2); seg(0, 0, !sl_nack, 1, 2);
              m_hold_sda = 0;
            end
            default: begin
              for (int b = 7; b >= 0; b--) begin
                seg(1, 0, !sl_byte[b], 0, 3); seg(0, 0, !sl_byte[b], 0, 3);
              end
              seg(1, cmd_ack, 0, 0, 3); seg(0, cmd_ack, 0, 1, 3);
              m_hold_sda = cmd_ack;
            end
          endcase
        end
      end
      if (q.size() > 0) begin
        m_cur  = q.pop_front();
        m_busy = 1;
      end else begin
        m_busy = 0;
        m_cur  = '0;
      end
    end
  end

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !fin) begin
      if (!m_busy) tg = "R10";
      else if (m_cur.kind == 2'd0) tg = "R2";
      else if (m_cur.kind == 2'd1) tg = "R3";
      else if (m_cur.kind == 2'd2) tg = "R4";
      else tg = "R8";
      chk(tg, "scl_low", scl_low, m_busy ? m_cur.scl : m_owned);
      chk(tg, "sda_low", sda_low, m_busy ? m_cur.sda : (m_owned && m_hold_sda));
      chk("R10", "cmd_ready", cmd_ready, !m_busy);
      chk("R5", "xfer_done", xfer_done, m_done);
      chk("R7", "ack_err", ack_err, m_ack_err);
      chk("R9", "ovr_err", ovr_err, m_ovr);
      chk("R9", "rx_valid", rx_valid, m_rx_valid);
      if (m_rx_valid) chk("R8", "rx_data", rx_data, m_rx_data);
      if (m_busy && m_cur.kind[1] && !prev_scl && !scl_low)
        chk("R6", "sda moved under released scl", int'(sda_low != prev_sda), 0);
      if (xfer_done) n_done++;
      prev_scl = scl_low;
      prev_sda = sda_low;
    end
  end

  task automatic send(input logic [1:0] op, input logic [7:0] d, input logic ack);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_data = d; cmd_ack = ack;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic wait_ready();
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL R10 watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R1: values held while in reset
    chk("R1", "scl_low in reset", scl_low, 0);
    chk("R1", "sda_low in reset", sda_low, 0);
    chk("R1", "cmd_ready in reset", cmd_ready, 1);
    chk("R1", "rx_valid in reset", rx_valid, 0);
    chk("R1", "errors in reset", {ack_err, ovr_err, xfer_done}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "scl/sda after reset", {scl_low, sda_low}, 0);

    // R11: stop, write, read on a free bus are dropped
    send(2'd1, 8'h00, 0);
    send(2'd2, 8'h55, 0);
    send(2'd3, 8'h00, 1);
    repeat (4 * HALF) @(negedge clk);
    chk("R11", "done pulses on free bus", n_done, 0);
    chk("R11", "lines on free bus", {scl_low, sda_low}, 0);

    // R2: start on free bus
    send(2'd0, 8'h00, 0); wait_ready();
    chk("R2", "held bus after start", {scl_low, sda_low}, 2'b11);

    // R4: address byte (7-bit 0x52, write) acknowledged
    sl_nack = 0;
    send(2'd2, 8'hA4, 0); wait_ready();
    chk("R5", "done count after write", n_done, 1);
    chk("R7", "ack_err after acked write", ack_err, 0);

    // R7: unacknowledged write
    sl_nack = 1;
    send(2'd2, 8'h3C, 0); wait_ready();
    chk("R7", "ack_err after nack", ack_err, 1);
    repeat (3) @(negedge clk);
    chk("R7", "ack_err sticky", ack_err, 1);
    sl_nack = 0;

    // R12: clear
    err_clr = 1; @(negedge clk); err_clr = 0; @(negedge clk);
    chk("R12", "ack_err cleared", ack_err, 0);

    // R2: repeated start, then read with ACK while consumer stalled
    send(2'd0, 8'h00, 0); wait_ready();
    rx_ready = 0;
    sl_byte = 8'h96;
    send(2'd3, 8'h00, 1); wait_ready();
    chk("R8", "rx byte", rx_data, 8'h96);
    repeat (5) @(negedge clk);
    chk("R9", "byte held under back-pressure", {rx_valid, rx_data}, {1'b1, 8'h96});

    // R9: second read, NACKed as last byte, overwrites
    sl_byte = 8'h5A;
    send(2'd3, 8'h00, 0); wait_ready();
    chk("R9", "overrun flagged", ovr_err, 1);
    chk("R9", "newer byte kept", rx_data, 8'h5A);
    @(negedge clk); rx_ready = 1; @(negedge clk); rx_ready = 0;
    chk("R9", "rx_valid after take", rx_valid, 0);

    // R12: clear overrun
    err_clr = 1; @(negedge clk); err_clr = 0; @(negedge clk);
    chk("R12", "ovr_err cleared", ovr_err, 0);

    // R3: stop
    send(2'd1, 8'h00, 0); wait_ready();
    chk("R3", "free bus after stop", {scl_low, sda_low}, 0);

    // more patterns: all ones, all zeros, read with ready consumer
    send(2'd0, 8'h00, 0); wait_ready();
    send(2'd2, 8'hFF, 0); wait_ready();
    send(2'd2, 8'h00, 0); wait_ready();
    rx_ready = 1;
    sl_byte = 8'h01;
    send(2'd3, 8'h00, 0); wait_ready();
    rx_ready = 0;
    chk("R9", "no overrun with ready consumer", ovr_err, 0);
    send(2'd1, 8'h00, 0); wait_ready();
    chk("R5", "total done pulses", n_done, 7);
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule